// File: doc/BRIEF.md
# External Interrupt Request Detector

This block turns two kinds of external interrupt inputs into one pending interrupt request for the CPU. The first input is a dedicated active-low pin, assumed already synchronized. The second is a group of active-high port pins. The port pins take part only when a port-interrupt enable bit is set. All port pins share one edge detector and one request latch.

A level-mode bit comes from nonvolatile configuration and changes the sensitivity of both sources at once. With the bit clear, only edges count: a falling edge on the dedicated pin, or a rising edge on the OR of the port pins. With the bit set, the same edges still count. In addition, the dedicated pin requests while it is held low, and the port group requests while any enabled pin is held high.

An edge sets a pending latch, and the latch holds until the CPU pulses the acknowledge strobe. A level condition that is still present after the acknowledge raises the request again. The edge-history registers load from the live pins in the first cycle after reset, so a pin already sitting in its active state at reset is not taken as an edge.

Top module: `ext_irq_detect`

## Requirements
- R1: Once `irqReq` is 1, it stays 1 in every following cycle until a cycle in which `ack` is 1.
- R2: A 1-to-0 transition of `irqN`, seen between two consecutive clock samples, makes `irqReq` 1 after the second sample. This holds whatever the value of `levelMode`.
- R3: With `levelMode` = 1, each clock sample that finds `irqN` = 0 (and `ack` = 0) makes `irqReq` 1 after that sample.
- R4: With `portEn` = 1, a 0-to-1 transition of the OR of all `portPins` bits makes `irqReq` 1 one sample later. A bit that rises while another bit is already 1 leaves the OR unchanged and is not an event.
- R5: With `levelMode` = 1 and `portEn` = 1, each sample that finds any `portPins` bit at 1 (and `ack` = 0) makes `irqReq` 1 after that sample.
- R6: With `portEn` = 0, `portPins` has no effect on `irqReq`, for both edges and levels.
- R7: A sample with `ack` = 1 makes `irqReq` 0 after it, unless an edge event is detected in that same sample. In that case `irqReq` stays 1.
- R8: With `levelMode` = 1, a level condition that is still present at an acknowledge leaves `irqReq` at 0 for exactly one cycle, then makes it 1 again.
- R9: While `rstN` is 0, `irqReq` is 0, independent of the clock.
- R10: The first clock sample after `rstN` rises captures the pins as edge history and reports no edge. Pins held active through reset therefore produce no request when `levelMode` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqN | input | 1 | Synchronized dedicated interrupt pin, active low |
| portPins | input | NUM_PORT_PINS | Synchronized port interrupt pins, active high |
| portEn | input | 1 | Enables the port pins as interrupt sources |
| levelMode | input | 1 | 1 adds level sensitivity to edge sensitivity on both sources |
| ack | input | 1 | Acknowledge strobe that clears the pending request |
| irqReq | output | 1 | Pending interrupt request to the CPU |

## Verification
The bench builds the block with its default of four port pins. This is enough to show the shared-OR behaviour: one pin rising while another is already high produces no event, and any single pin out of four can raise a request on its own. With four pins, the bench can also hold every pin high through reset and confirm that the history preload hides the would-be edge. With that width it also covers acknowledges that collide with an edge and level conditions that survive an acknowledge.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadHist;   // capture live pins into edge history
    logic armEdges;   // allow edge events to be reported
  } irq_ctrl_t;

  // Qualified event conditions from the datapath
  typedef struct packed {
    logic dedEdge;
    logic dedLevel;
    logic portEdge;
    logic portLevel;
  } irq_evt_t;

endpackage

// File: rtl/ext_irq_datapath.sv
module ext_irq_datapath
  import ext_irq_pkg::*;
#(
  parameter int NUM_PORT_PINS = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  irq_ctrl_t                ctrl,
  input  logic                     irqN,
  input  logic [NUM_PORT_PINS-1:0] portPins,
  input  logic                     portEn,
  input  logic                     levelMode,
  output irq_evt_t                 evt
);

  localparam int LAST_PIN = NUM_PORT_PINS - 1;

  // Per-pin OR chain
  logic [NUM_PORT_PINS-1:0] orChain;
  genvar gi;
  generate
    for (gi = 0; gi < NUM_PORT_PINS; gi++) begin : g_or
      if (gi == 0) begin : g_first
        assign orChain[gi] = portPins[gi];
      end else begin : g_rest
        assign orChain[gi] = orChain[gi-1] | portPins[gi];
      end
    end
  endgenerate

  logic portAny;
  assign portAny = orChain[LAST_PIN];

  logic dedHist;
  logic portHist;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dedHist  <= 1'b0;
      portHist <= 1'b0;
    end else begin
      // Every armed or loading cycle tracks the live pins
      dedHist  <= irqN;
      portHist <= portAny;
    end
  end

  always_comb begin
    evt.dedEdge   = ctrl.armEdges & dedHist & ~irqN;
    evt.portEdge  = ctrl.armEdges & portEn & ~portHist & portAny;
    evt.dedLevel  = levelMode & ~irqN;
    evt.portLevel = levelMode & portEn & portAny;
  end

  // Assertions
  a_r2_fall_detect: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.armEdges && $fell(irqN)) |-> evt.dedEdge)
    else $error("falling edge on irqN not detected");

  a_r4_rise_detect: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.armEdges && portEn && $rose(|portPins)) |-> evt.portEdge)
    else $error("rising port OR not detected");

  a_r6_port_gate: assert property (@(posedge clk) disable iff (!rstN)
    !portEn |-> !(evt.portEdge || evt.portLevel))
    else $error("port event while disabled");

  a_r10_quiet_first: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadHist |-> !(evt.dedEdge || evt.portEdge))
    else $error("edge reported during history load");

endmodule

// File: rtl/ext_irq_control.sv
module ext_irq_control
  import ext_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  irq_evt_t  evt,
  input  logic      ack,
  output irq_ctrl_t ctrl,
  output logic      pending
);

  logic armed;
  logic anyEdge;
  logic anyLevel;
  logic pendingNext;

  assign anyEdge  = evt.dedEdge | evt.portEdge;
  assign anyLevel = evt.dedLevel | evt.portLevel;

  // Edge wins over ack; level and hold yield to ack
  assign pendingNext = anyEdge | ((anyLevel | pending) & ~ack);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      pending <= 1'b0;
    end else begin
      armed   <= 1'b1;
      pending <= pendingNext;
    end
  end

  always_comb begin
    ctrl.loadHist = ~armed;
    ctrl.armEdges = armed;
  end

  // Assertions
  a_r1_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !ack) |=> pending)
    else $error("request dropped without ack");

  a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rstN)
    evt.dedEdge |=> pending)
    else $error("dedicated edge did not set request");

  a_r3_level_sets: assert property (@(posedge clk) disable iff (!rstN)
    (evt.dedLevel && !ack) |=> pending)
    else $error("dedicated level did not set request");

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !evt.dedEdge && !evt.portEdge) |=> !pending)
    else $error("ack did not clear request");

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter int NUM_PORT_PINS = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     irqN,
  input  logic [NUM_PORT_PINS-1:0] portPins,
  input  logic                     portEn,
  input  logic                     levelMode,
  input  logic                     ack,
  output logic                     irqReq
);

  irq_ctrl_t ctrl;
  irq_evt_t  evt;

  ext_irq_datapath #(.NUM_PORT_PINS(NUM_PORT_PINS)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .irqN      (irqN),
    .portPins  (portPins),
    .portEn    (portEn),
    .levelMode (levelMode),
    .evt       (evt)
  );

  ext_irq_control ctl_i (
    .clk     (clk),
    .rstN    (rstN),
    .evt     (evt),
    .ack     (ack),
    .ctrl    (ctrl),
    .pending (irqReq)
  );

  a_r9_reset_low: assert property (@(posedge clk)
    !rstN |-> !irqReq)
    else $error("request high in reset");

endmodule

// File: tb/ext_irq_detect_tb_top.sv
`timescale 1ns/1ps
module ext_irq_detect_tb_top;

  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          irqN = 1'b1;
  logic [NP-1:0] portPins = '0;
  logic          portEn = 1'b1;
  logic          levelMode = 1'b0;
  logic          ack = 1'b0;
  logic          irqReq;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  ext_irq_detect #(.NUM_PORT_PINS(NP)) dut_i (
    .clk(clk), .rstN(rstN), .irqN(irqN), .portPins(portPins),
    .portEn(portEn), .levelMode(levelMode), .ack(ack), .irqReq(irqReq)
  );

  // {req[3:0], irqN, pins[3:0], portEn, levelMode, ack, expected}
  localparam int NV = 26;
  localparam logic [12:0] VEC [NV] = '{
    {4'd1,  1'b1, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0}, // idle
    {4'd2,  1'b0, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b1}, // R2 fall
    {4'd1,  1'b0, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b1}, // R1 hold
    {4'd7,  1'b1, 4'b0000, 1'b1, 1'b0, 1'b1, 1'b0}, // R7 ack
    {4'd1,  1'b1, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 rise of irqN no event
    {4'd4,  1'b1, 4'b0001, 1'b1, 1'b0, 1'b0, 1'b1}, // R4 rise pin0
    {4'd4,  1'b1, 4'b0011, 1'b1, 1'b0, 1'b1, 1'b0}, // R4 second pin, OR unchanged
    {4'd4,  1'b1, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 fall no event
    {4'd6,  1'b1, 4'b1000, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 disabled edge
    {4'd6,  1'b1, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    {4'd4,  1'b1, 4'b0100, 1'b1, 1'b0, 1'b0, 1'b1}, // R4 rise pin2
    {4'd7,  1'b1, 4'b0000, 1'b1, 1'b0, 1'b1, 1'b0}, // R7 ack
    {4'd3,  1'b0, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b1}, // R3 fall+level
    {4'd8,  1'b0, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b0}, // R8 ack with level
    {4'd8,  1'b0, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b1}, // R8 reassert
    {4'd7,  1'b1, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b0}, // R7 ack, level gone
    {4'd3,  1'b1, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b0}, // R3 no level
    {4'd5,  1'b1, 4'b0010, 1'b1, 1'b1, 1'b0, 1'b1}, // R5 rise+level
    {4'd8,  1'b1, 4'b0010, 1'b1, 1'b1, 1'b1, 1'b0}, // R8 ack
    {4'd5,  1'b1, 4'b0010, 1'b1, 1'b1, 1'b0, 1'b1}, // R5 level reassert
    {4'd6,  1'b1, 4'b0010, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 ack, disabled
    {4'd6,  1'b1, 4'b0010, 1'b0, 1'b1, 1'b0, 1'b0}, // R6 level ignored
    {4'd5,  1'b1, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 quiet
    {4'd7,  1'b0, 4'b0000, 1'b1, 1'b0, 1'b1, 1'b1}, // R7 edge beats ack
    {4'd7,  1'b0, 4'b0000, 1'b1, 1'b0, 1'b1, 1'b0}, // R7 edge-only, held low
    {4'd1,  1'b1, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0}  // R1 idle
  };

  task automatic check(input string req, input logic exp);
    tests++;
    if (irqReq !== exp) begin
      fails++;
      $display("FAIL %s: irqReq=%b expected=%b at %0t", req, irqReq, exp, $time);
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: expired, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    check("R9", 1'b0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R10", 1'b0);

    for (int i = 0; i < NV; i++) begin
      irqN      = VEC[i][8];
      portPins  = VEC[i][7:4];
      portEn    = VEC[i][3];
      levelMode = VEC[i][2];
      ack       = VEC[i][1];
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VEC[i][12:9], i), VEC[i][0]);
    end
    ack = 1'b0;

    // R9 asynchronous reset clears a pending request
    irqN = 1'b1;
    @(negedge clk);
    irqN = 1'b0;
    @(negedge clk);
    check("R2", 1'b1);
    #2 rstN = 1'b0;
    #1 check("R9", 1'b0);

    // R10 pins active through reset: no false edge
    portPins  = '1;
    portEn    = 1'b1;
    levelMode = 1'b0;
    irqN      = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10", 1'b0);
    end

    // R2 detection is armed after the quiet cycle
    portPins = '0;
    irqN = 1'b1;
    @(negedge clk);
    irqN = 1'b0;
    @(negedge clk);
    check("R2", 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule